// File: doc/BRIEF.md
# Engine Method Register Dispatcher

This block sits in front of one processing engine. It takes in a stream of register writes, each an offset and a data word. Every write whose offset falls inside a small word-addressed register file is stored there. Two offsets have a special meaning.

A write to the trigger offset issues a method call on the call port. The call carries the method id that an earlier write left in the method-id register, and it uses the newly written data as its argument. A method call therefore takes two writes: one that loads the id and one that fires it with an argument.

A write to the syncpoint offset requests a syncpoint increment. Data bits 7:0 give the syncpoint id and bits 15:8 give a condition code. A zero code issues the increment at once. A nonzero code puts the id in a small queue. Each done pulse from the engine then releases one queued id, oldest first. The engine and the syncpoint counters lie outside this block.

Top module: `method_dispatch_top`

## Requirements
- R1: After reset, `callValid`, `syncValid` and `overflow` are low.
- R2: A write to offset `TRIG_OFF` (default 17) sets `callValid` high for exactly the following cycle. In that cycle `callArg` equals the written data and `callId` equals the method-id register's content from before the write.
- R3: Every write with an offset below `RF_DEPTH` (default 32) stores its data in that register-file word. The method-id register is word `MID_OFF` (default 16). A write to the trigger offset leaves the method-id register unchanged.
- R4: A write with an offset of `RF_DEPTH` or above changes no register-file word. For example, offset `MID_OFF + RF_DEPTH` does not alter the method id.
- R5: A write to offset `SYNC_OFF` (default 0) with data bits 15:8 equal to zero sets `syncValid` high for the following cycle, with `syncId` equal to data bits 7:0.
- R6: A write to `SYNC_OFF` with nonzero data bits 15:8 emits nothing at once. It queues data bits 7:0. Each `engineDone` pulse releases the oldest queued id on `syncId` with `syncValid` in the following cycle, so ids leave in arrival order.
- R7: An `engineDone` pulse while the queue is empty produces no output and leaves no credit behind. A later queued id waits for its own done pulse.
- R8: A deferred request that arrives while the queue holds `Q_DEPTH` (default 4) entries is dropped. It raises `overflow` for exactly the following cycle.
- R9: When an immediate increment and a done-driven release fall in the same cycle, the immediate id goes out first. The release follows in the next free cycle.
- R10: Writes to any other offset produce no call and no syncpoint output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Register write strobe |
| wrOffset | input | OFF_W (12) | Word offset of the write |
| wrData | input | DATA_W (32) | Write data |
| engineDone | input | 1 | Engine completion pulse, releases one queued syncpoint |
| callValid | output | 1 | Method call issued this cycle |
| callId | output | DATA_W (32) | Method id of the call |
| callArg | output | DATA_W (32) | Argument of the call |
| syncValid | output | 1 | Syncpoint increment issued this cycle |
| syncId | output | 8 | Syncpoint to increment |
| overflow | output | 1 | A deferred request was dropped because the queue was full |

## Verification
A register-file write that goes to the wrong word shows up only at the next trigger write, through a wrong `callId`. The bench therefore fires a call after every id load and after every out-of-range write. If the queue pointers or the release credit are wrong, `syncId` values come out in the wrong order, arrive one cycle early or late, or appear without a done pulse. Each of these shows in the cycle after the causing input, so every release is checked on that exact cycle, along with the idle cycles in between.

// File: rtl/method_dispatch_pkg.sv
package method_dispatch_pkg;
  localparam int SID_W = 8;

  typedef struct packed {
    logic rfWrite;
    logic callFire;
    logic immFire;
    logic push;
    logic pop;
    logic ovf;
  } dispatchStrobes_t;
endpackage

// File: rtl/method_dispatch_ctrl.sv
module method_dispatch_ctrl
  import method_dispatch_pkg::*;
#(
  parameter int OFF_W    = 12,
  parameter int RF_DEPTH = 32,
  parameter int SYNC_OFF = 0,
  parameter int TRIG_OFF = 17,
  parameter int Q_DEPTH  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [OFF_W-1:0] wrOffset,
  input  logic [7:0]       condCode,
  input  logic             engineDone,
  output dispatchStrobes_t strobes
);
  localparam int CNT_W = $clog2(Q_DEPTH + 1);
  localparam logic [OFF_W-1:0] RF_LIMIT = OFF_W'(RF_DEPTH);
  localparam logic [OFF_W-1:0] SYNC_A   = OFF_W'(SYNC_OFF);
  localparam logic [OFF_W-1:0] TRIG_A   = OFF_W'(TRIG_OFF);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(Q_DEPTH);

  logic [CNT_W-1:0] qCount;
  logic [CNT_W-1:0] owedCnt;
  logic [CNT_W:0]   want;
  logic [CNT_W:0]   owedRaw;
  logic [CNT_W:0]   owedCap;
  logic             syncHit;
  logic             deferReq;
  logic             qFull;

  always_comb begin
    syncHit  = wrValid && (wrOffset == SYNC_A);
    deferReq = syncHit && (condCode != 8'd0);
    qFull    = (qCount == FULL_CNT);

    strobes.rfWrite  = wrValid && (wrOffset < RF_LIMIT);
    strobes.callFire = wrValid && (wrOffset == TRIG_A);
    strobes.immFire  = syncHit && (condCode == 8'd0);
    strobes.push     = deferReq && !qFull;
    strobes.ovf      = deferReq && qFull;

    want        = {1'b0, owedCnt} + {{CNT_W{1'b0}}, engineDone};
    strobes.pop = (want != '0) && (qCount != '0) && !strobes.immFire;

    owedRaw = strobes.pop ? (want - 1'b1) : want;
    owedCap = {1'b0, qCount} - {{CNT_W{1'b0}}, strobes.pop};
    if (owedRaw > owedCap) owedRaw = owedCap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCount  <= '0;
      owedCnt <= '0;
    end else begin
      qCount  <= qCount + CNT_W'(strobes.push) - CNT_W'(strobes.pop);
      owedCnt <= owedRaw[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/method_dispatch_data.sv
module method_dispatch_data
  import method_dispatch_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RF_DEPTH = 32,
  parameter int MID_OFF  = 16,
  parameter int Q_DEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dispatchStrobes_t            strobes,
  input  logic [$clog2(RF_DEPTH)-1:0] wrIdx,
  input  logic [DATA_W-1:0]           wrData,
  output logic                        callValid,
  output logic [DATA_W-1:0]           callId,
  output logic [DATA_W-1:0]           callArg,
  output logic                        syncValid,
  output logic [SID_W-1:0]            syncId,
  output logic                        overflow
);
  localparam int AW    = $clog2(RF_DEPTH);
  localparam int PTR_W = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(Q_DEPTH - 1);

  logic [DATA_W-1:0] regFile [RF_DEPTH];
  logic [SID_W-1:0]  queue   [Q_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  for (genvar gi = 0; gi < RF_DEPTH; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) regFile[gi] <= '0;
      else if (strobes.rfWrite && (wrIdx == AW'(gi))) regFile[gi] <= wrData;
    end
  end

  for (genvar gq = 0; gq < Q_DEPTH; gq++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) queue[gq] <= '0;
      else if (strobes.push && (wrPtr == PTR_W'(gq))) queue[gq] <= wrData[SID_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      callValid <= 1'b0;
      callId    <= '0;
      callArg   <= '0;
      syncValid <= 1'b0;
      syncId    <= '0;
      overflow  <= 1'b0;
    end else begin
      if (strobes.push) wrPtr <= (wrPtr == LAST_P) ? '0 : wrPtr + 1'b1;
      if (strobes.pop)  rdPtr <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
      callValid <= strobes.callFire;
      if (strobes.callFire) begin
        callId  <= regFile[MID_OFF];
        callArg <= wrData;
      end
      syncValid <= strobes.immFire || strobes.pop;
      if (strobes.immFire)  syncId <= wrData[SID_W-1:0];
      else if (strobes.pop) syncId <= queue[rdPtr];
      overflow <= strobes.ovf;
    end
  end
endmodule

// File: rtl/method_dispatch_top.sv
module method_dispatch_top
  import method_dispatch_pkg::*;
#(
  parameter int OFF_W    = 12,
  parameter int DATA_W   = 32,
  parameter int RF_DEPTH = 32,
  parameter int SYNC_OFF = 0,
  parameter int MID_OFF  = 16,
  parameter int TRIG_OFF = 17,
  parameter int Q_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [OFF_W-1:0]  wrOffset,
  input  logic [DATA_W-1:0] wrData,
  input  logic              engineDone,
  output logic              callValid,
  output logic [DATA_W-1:0] callId,
  output logic [DATA_W-1:0] callArg,
  output logic              syncValid,
  output logic [7:0]        syncId,
  output logic              overflow
);
  localparam int AW = $clog2(RF_DEPTH);

  dispatchStrobes_t strobes;

  method_dispatch_ctrl #(
    .OFF_W(OFF_W), .RF_DEPTH(RF_DEPTH), .SYNC_OFF(SYNC_OFF),
    .TRIG_OFF(TRIG_OFF), .Q_DEPTH(Q_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrOffset(wrOffset),
    .condCode(wrData[15:8]), .engineDone(engineDone), .strobes(strobes)
  );

  method_dispatch_data #(
    .DATA_W(DATA_W), .RF_DEPTH(RF_DEPTH), .MID_OFF(MID_OFF), .Q_DEPTH(Q_DEPTH)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrOffset[AW-1:0]),
    .wrData(wrData), .callValid(callValid), .callId(callId), .callArg(callArg),
    .syncValid(syncValid), .syncId(syncId), .overflow(overflow)
  );
endmodule

// File: rtl/method_dispatch_checker.sv
module method_dispatch_checker #(
  parameter int OFF_W    = 12,
  parameter int DATA_W   = 32,
  parameter int SYNC_OFF = 0,
  parameter int TRIG_OFF = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [OFF_W-1:0]  wrOffset,
  input logic [DATA_W-1:0] wrData,
  input logic              callValid,
  input logic [DATA_W-1:0] callArg,
  input logic              syncValid,
  input logic [7:0]        syncId,
  input logic              overflow
);
  logic trigW, immW, defW;
  assign trigW = wrValid && (wrOffset == OFF_W'(TRIG_OFF));
  assign immW  = wrValid && (wrOffset == OFF_W'(SYNC_OFF)) && (wrData[15:8] == 8'd0);
  assign defW  = wrValid && (wrOffset == OFF_W'(SYNC_OFF)) && (wrData[15:8] != 8'd0);

  // R2: trigger write yields a call carrying the written data
  a_r2_call_on_trigger: assert property (@(posedge clk) disable iff (!rstN)
    trigW |=> (callValid && callArg == $past(wrData)));

  // R10: no call without a trigger write
  a_r10_no_stray_call: assert property (@(posedge clk) disable iff (!rstN)
    !trigW |=> !callValid);

  // R5: immediate increment carries data bits 7:0
  a_r5_immediate_sync: assert property (@(posedge clk) disable iff (!rstN)
    immW |=> (syncValid && syncId == $past(wrData[7:0])));

  // R8: overflow only after a deferred request
  a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rstN)
    !defW |=> !overflow);
endmodule

bind method_dispatch_top method_dispatch_checker #(
  .OFF_W(OFF_W), .DATA_W(DATA_W), .SYNC_OFF(SYNC_OFF), .TRIG_OFF(TRIG_OFF)
) u_checker (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrOffset(wrOffset), .wrData(wrData),
  .callValid(callValid), .callArg(callArg), .syncValid(syncValid),
  .syncId(syncId), .overflow(overflow)
);

// File: tb/tb_method_dispatch_top.sv
module tb_method_dispatch_top;
  localparam int SYNC_OFF = 0;
  localparam int MID_OFF  = 16;
  localparam int TRIG_OFF = 17;
  localparam int RF_DEPTH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [11:0] wrOffset = '0;
  logic [31:0] wrData = '0;
  logic        engineDone = 1'b0;
  logic        callValid, syncValid, overflow;
  logic [31:0] callId, callArg;
  logic [7:0]  syncId;

  int total = 0;
  int failed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  method_dispatch_top dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrOffset(wrOffset), .wrData(wrData),
    .engineDone(engineDone), .callValid(callValid), .callId(callId), .callArg(callArg),
    .syncValid(syncValid), .syncId(syncId), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of inputs; outputs reflect it on return
  task automatic cyc(input bit wv, input int off, input logic [31:0] d, input bit done);
    wrValid = wv; wrOffset = 12'(off); wrData = d; engineDone = done;
    @(posedge clk); #1;
    wrValid = 1'b0; engineDone = 1'b0;
  endtask

  task automatic expectSync(input bit v, input logic [7:0] id, input string req);
    chk(syncValid == v, req, 32'(syncValid), 32'(v));
    if (v) chk(syncId == id, req, 32'(syncId), 32'(id));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] idNow;
    repeat (3) @(posedge clk); #1;
    chk(!callValid, "R1", 32'(callValid), 0);
    chk(!syncValid, "R1", 32'(syncValid), 0);
    chk(!overflow, "R1", 32'(overflow), 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R2/R3: id load then trigger, swept
    for (int i = 0; i < 16; i++) begin
      idNow = 32'(i) * 32'h0101_0111 + 32'd5;
      cyc(1, MID_OFF, idNow, 0);
      chk(!callValid, "R10", 32'(callValid), 0);
      cyc(1, TRIG_OFF, 32'hA000_0000 + 32'(i), 0);
      chk(callValid, "R2", 32'(callValid), 1);
      chk(callId == idNow, "R2", callId, idNow);
      chk(callArg == 32'hA000_0000 + 32'(i), "R2", callArg, 32'hA000_0000 + 32'(i));
      cyc(0, 0, 0, 0);
      chk(!callValid, "R2", 32'(callValid), 0);
    end
    // R3: trigger write leaves method id alone
    cyc(1, TRIG_OFF, 32'h1234, 0);
    cyc(1, TRIG_OFF, 32'h5678, 0);
    chk(callId == idNow, "R3", callId, idNow);

    // R4: out-of-range offsets alias-free
    for (int k = 1; k < 4; k++) begin
      cyc(1, MID_OFF + k * RF_DEPTH, 32'hDEAD_0000 + 32'(k), 0);
      chk(!callValid && !syncValid, "R4", 32'({callValid, syncValid}), 0);
      cyc(1, TRIG_OFF, 32'h1, 0);
      chk(callId == idNow, "R4", callId, idNow);
    end

    // R10: ordinary offsets do nothing visible
    for (int o = 1; o < 64; o++) begin
      if (o == TRIG_OFF || o == MID_OFF) continue;
      cyc(1, o, 32'hFFFF_FFFF, 0);
      chk(!callValid && !syncValid, "R10", 32'({callValid, syncValid}), 0);
    end

    // R5: immediate sweep over every id
    for (int s = 0; s < 256; s++) begin
      cyc(1, SYNC_OFF, 32'hFFFF_0000 | 32'(s), 0);
      expectSync(1, 8'(s), "R5");
    end
    cyc(0, 0, 0, 0);
    expectSync(0, 0, "R5");

    // R6: deferred ids released in order, one per done
    cyc(1, SYNC_OFF, 32'h0000_0111, 0); expectSync(0, 0, "R6");
    cyc(1, SYNC_OFF, 32'h0000_0222, 0); expectSync(0, 0, "R6");
    cyc(1, SYNC_OFF, 32'h0000_FF33, 0); expectSync(0, 0, "R6");
    cyc(0, 0, 0, 0); expectSync(0, 0, "R6");
    cyc(0, 0, 0, 1); expectSync(1, 8'h11, "R6");
    cyc(0, 0, 0, 0); expectSync(0, 0, "R6");
    cyc(0, 0, 0, 1); expectSync(1, 8'h22, "R6");
    cyc(0, 0, 0, 1); expectSync(1, 8'h33, "R6");

    // R7: done on empty queue leaves no credit
    cyc(0, 0, 0, 1); expectSync(0, 0, "R7");
    cyc(0, 0, 0, 1); expectSync(0, 0, "R7");
    cyc(1, SYNC_OFF, 32'h0000_0144, 0); expectSync(0, 0, "R7");
    cyc(0, 0, 0, 0); expectSync(0, 0, "R7");
    cyc(0, 0, 0, 0); expectSync(0, 0, "R7");
    cyc(0, 0, 0, 1); expectSync(1, 8'h44, "R7");

    // R8: overflow when full, entry dropped
    for (int q = 0; q < 4; q++) begin
      cyc(1, SYNC_OFF, 32'h0000_0250 + 32'(q), 0);
      chk(!overflow, "R8", 32'(overflow), 0);
    end
    cyc(1, SYNC_OFF, 32'h0000_0299, 0);
    chk(overflow, "R8", 32'(overflow), 1);
    cyc(0, 0, 0, 0);
    chk(!overflow, "R8", 32'(overflow), 0);
    for (int q = 0; q < 4; q++) begin
      cyc(0, 0, 0, 1); expectSync(1, 8'h50 + 8'(q), "R8");
    end
    cyc(0, 0, 0, 1); expectSync(0, 0, "R8");

    // R9: immediate beats a simultaneous release, release follows
    cyc(1, SYNC_OFF, 32'h0000_0177, 0); expectSync(0, 0, "R9");
    cyc(1, SYNC_OFF, 32'h0000_0088, 1); expectSync(1, 8'h88, "R9");
    cyc(0, 0, 0, 0); expectSync(1, 8'h77, "R9");
    cyc(0, 0, 0, 0); expectSync(0, 0, "R9");

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule